// File: doc/BRIEF.md
# Array Operation Arbiter and Status Register

This block decides which memory operations may start and keeps the status byte of a serial flash memory. Each request carries a 4-bit operation code. Codes that touch the flash array, such as page read, transfers, compares, programs and erases, form the array class. Buffer reads, buffer writes and status reads form the buffer class. An accepted array-class request starts a busy interval whose length stands in for the self-timed array work. While that interval runs, further array-class requests are refused with a one-cycle reject pulse, and buffer-class requests are still granted. One buffer can therefore be loaded while the array is being programmed from the other.

Some operations have two steps. Program with erase, program through buffer and auto rewrite each run two phases back to back, and the busy flag stays high across the change from one phase to the next. The status byte reports ready or busy in its top bit and the result of the last completed compare in bit 6. The compare result is posted only when the compare finishes.

Top module: `opx_arbiter`

## Requirements
- R1: After reset, grant_o and reject_o are 0, busy_o is 0, phase_o is 0, and status_o equals {1'b1, 1'b0, DEV_CODE[3:0], 2'b00}.
- R2: A buffer-class request (code 0 buffer read, 1 buffer write, 2 status read) gives grant_o=1 for exactly the cycle after it is sampled, whether or not the block is busy. It does not change busy_o, phase_o or status_o[6].
- R3: An array-class request (codes 3..11) sampled while busy_o=0 gives grant_o=1 in the next cycle. busy_o then stays 1 for exactly the operation's total cycle count.
- R4: An array-class request sampled while busy_o=1 gives reject_o=1 for one cycle. The current busy interval keeps its original length and phase sequence.
- R5: Two-phase operations keep busy_o high with no gap between the phases. The phases are code 6 program with erase (erase then program), code 10 program through buffer (erase then program) and code 11 auto rewrite (transfer then program). phase_o is 1 for the first phase's cycles and 2 for the second phase's cycles. It is 0 when idle.
- R6: status_o[7] is 1 exactly when busy_o is 0.
- R7: A compare (code 5) samples req_cmp_diff_i when it is accepted. status_o[6] keeps its old value during the busy interval and takes the sampled value in the first cycle after busy ends. No other request changes status_o[6].
- R8: Codes 12..15 are always rejected with reject_o=1 for one cycle, and they start nothing.
- R9: Single-phase durations are T_READ for code 3, T_XFR for codes 4 and 5, T_PGM for code 7, T_ERASE for code 8 and T_BERASE for code 9. status_o[5:0] always equals {DEV_CODE, 2'b00}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, sampled on each rising edge |
| req_op_i | input | 4 | Operation code of the request |
| req_cmp_diff_i | input | 1 | Compare outcome to post when a compare request completes |
| grant_o | output | 1 | One-cycle pulse: request accepted |
| reject_o | output | 1 | One-cycle pulse: request refused |
| busy_o | output | 1 | Array operation in progress |
| phase_o | output | 2 | 0 idle, 1 first phase, 2 second phase |
| status_o | output | 8 | Status byte: ready, compare result, device code, zeros |

## Verification
Faults in the countdown or the phase register show up as a wrong busy length or a wrong phase_o value, and they are visible within one cycle of the wrong transition. A lost pending second phase shows as a ready gap or an early drop of busy_o. The bench sweeps every code while the block is idle, and it sweeps every code as an intruder against every array operation. A wrong class decode therefore appears as a grant or reject pulse of the wrong kind in the cycle after the request. A compare flag posted at the wrong time, or captured from a rejected request, shows in status_o[6] either during the busy interval or in the first ready cycle.

// File: rtl/opx_pkg.sv
package opx_pkg;
  typedef enum logic [2:0] {
    DUR_READ   = 3'd0,
    DUR_XFR    = 3'd1,
    DUR_PGM    = 3'd2,
    DUR_ERASE  = 3'd3,
    DUR_BERASE = 3'd4
  } dur_e;

  typedef struct packed {
    logic known;
    logic grp_a;
    logic two_ph;
    logic is_cmp;
    dur_e dur1;
    dur_e dur2;
  } op_cls_t;

  localparam logic [3:0] OP_BUF_RD      = 4'd0;
  localparam logic [3:0] OP_BUF_WR      = 4'd1;
  localparam logic [3:0] OP_STAT_RD     = 4'd2;
  localparam logic [3:0] OP_PAGE_RD     = 4'd3;
  localparam logic [3:0] OP_XFR         = 4'd4;
  localparam logic [3:0] OP_CMP         = 4'd5;
  localparam logic [3:0] OP_PGM_ERASE   = 4'd6;
  localparam logic [3:0] OP_PGM_NOERASE = 4'd7;
  localparam logic [3:0] OP_PAGE_ERASE  = 4'd8;
  localparam logic [3:0] OP_BLK_ERASE   = 4'd9;
  localparam logic [3:0] OP_PGM_THRU    = 4'd10;
  localparam logic [3:0] OP_REWRITE     = 4'd11;
endpackage

// File: rtl/opx_decode.sv
module opx_decode
  import opx_pkg::*;
(
  input  logic [3:0] op_i,
  output op_cls_t    cls_o
);
  always_comb begin
    cls_o.known  = 1'b1;
    cls_o.grp_a  = 1'b1;
    cls_o.two_ph = 1'b0;
    cls_o.is_cmp = 1'b0;
    cls_o.dur1   = DUR_READ;
    cls_o.dur2   = DUR_PGM;
    unique case (op_i)
      OP_BUF_RD, OP_BUF_WR, OP_STAT_RD: cls_o.grp_a = 1'b0;
      OP_PAGE_RD:     cls_o.dur1 = DUR_READ;
      OP_XFR:         cls_o.dur1 = DUR_XFR;
      OP_CMP: begin
        cls_o.dur1   = DUR_XFR;
        cls_o.is_cmp = 1'b1;
      end
      OP_PGM_ERASE, OP_PGM_THRU: begin
        cls_o.dur1   = DUR_ERASE;
        cls_o.two_ph = 1'b1;
      end
      OP_PGM_NOERASE: cls_o.dur1 = DUR_PGM;
      OP_PAGE_ERASE:  cls_o.dur1 = DUR_ERASE;
      OP_BLK_ERASE:   cls_o.dur1 = DUR_BERASE;
      OP_REWRITE: begin
        cls_o.dur1   = DUR_XFR;
        cls_o.two_ph = 1'b1;
      end
      default: begin
        cls_o.known = 1'b0;
        cls_o.grp_a = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/opx_busy_timer.sv
module opx_busy_timer
  import opx_pkg::*;
#(
  parameter int unsigned T_READ   = 3,
  parameter int unsigned T_XFR    = 5,
  parameter int unsigned T_PGM    = 7,
  parameter int unsigned T_ERASE  = 4,
  parameter int unsigned T_BERASE = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       launch_i,
  input  logic       two_ph_i,
  input  dur_e       dur1_i,
  input  dur_e       dur2_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [1:0] phase_o
);
  localparam int unsigned M1    = (T_READ > T_XFR) ? T_READ : T_XFR;
  localparam int unsigned M2    = (T_PGM > T_ERASE) ? T_PGM : T_ERASE;
  localparam int unsigned M3    = (M1 > M2) ? M1 : M2;
  localparam int unsigned T_MAX = (M3 > T_BERASE) ? M3 : T_BERASE;
  localparam int unsigned CNT_W = $clog2(T_MAX + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             pend2_q;
  dur_e             dur2_q;
  logic [1:0]       phase_q;

  function automatic logic [CNT_W-1:0] dur_cycles(dur_e d);
    unique case (d)
      DUR_READ:   return CNT_W'(T_READ);
      DUR_XFR:    return CNT_W'(T_XFR);
      DUR_PGM:    return CNT_W'(T_PGM);
      DUR_ERASE:  return CNT_W'(T_ERASE);
      DUR_BERASE: return CNT_W'(T_BERASE);
      default:    return CNT_W'(T_MAX);
    endcase
  endfunction

  logic last_cyc;
  assign last_cyc = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pend2_q <= 1'b0;
      dur2_q  <= DUR_PGM;
      phase_q <= 2'd0;
    end else if (launch_i) begin
      cnt_q   <= dur_cycles(dur1_i);
      pend2_q <= two_ph_i;
      dur2_q  <= dur2_i;
      phase_q <= 2'd1;
    end else if (cnt_q != '0) begin
      if (last_cyc && pend2_q) begin
        // chain straight into phase two: no ready gap
        cnt_q   <= dur_cycles(dur2_q);
        pend2_q <= 1'b0;
        phase_q <= 2'd2;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (last_cyc) phase_q <= 2'd0;
      end
    end
  end

  assign busy_o  = (cnt_q != '0);
  assign done_o  = last_cyc && !pend2_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/opx_status.sv
module opx_status #(
  parameter logic [3:0] DEV_CODE = 4'b0101
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       launch_i,
  input  logic       launch_cmp_i,
  input  logic       diff_i,
  input  logic       done_i,
  input  logic       busy_i,
  output logic [7:0] status_o
);
  logic cmp_pend_q, cmp_val_q, cmp_bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_pend_q <= 1'b0;
      cmp_val_q  <= 1'b0;
      cmp_bit_q  <= 1'b0;
    end else if (launch_i) begin
      cmp_pend_q <= launch_cmp_i;
      cmp_val_q  <= diff_i;
    end else if (done_i) begin
      cmp_pend_q <= 1'b0;
      if (cmp_pend_q) cmp_bit_q <= cmp_val_q;
    end
  end

  assign status_o = {~busy_i, cmp_bit_q, DEV_CODE, 2'b00};
endmodule

// File: rtl/opx_arbiter.sv
module opx_arbiter
  import opx_pkg::*;
#(
  parameter int unsigned T_READ   = 3,
  parameter int unsigned T_XFR    = 5,
  parameter int unsigned T_PGM    = 7,
  parameter int unsigned T_ERASE  = 4,
  parameter int unsigned T_BERASE = 9,
  parameter logic [3:0]  DEV_CODE = 4'b0101
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic [3:0] req_op_i,
  input  logic       req_cmp_diff_i,
  output logic       grant_o,
  output logic       reject_o,
  output logic       busy_o,
  output logic [1:0] phase_o,
  output logic [7:0] status_o
);
  op_cls_t cls;
  logic    busy, done, launch, grant_d, reject_d;
  logic    grant_q, reject_q;

  opx_decode u_decode (.op_i(req_op_i), .cls_o(cls));

  assign launch   = req_valid_i && cls.known && cls.grp_a && !busy;
  assign grant_d  = req_valid_i && cls.known && (!cls.grp_a || !busy);
  assign reject_d = req_valid_i && !grant_d;

  opx_busy_timer #(
    .T_READ(T_READ), .T_XFR(T_XFR), .T_PGM(T_PGM),
    .T_ERASE(T_ERASE), .T_BERASE(T_BERASE)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .launch_i(launch),
    .two_ph_i(cls.two_ph), .dur1_i(cls.dur1), .dur2_i(cls.dur2),
    .busy_o(busy), .done_o(done), .phase_o(phase_o)
  );

  opx_status #(.DEV_CODE(DEV_CODE)) u_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .launch_i(launch),
    .launch_cmp_i(cls.is_cmp), .diff_i(req_cmp_diff_i),
    .done_i(done), .busy_i(busy), .status_o(status_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q  <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      grant_q  <= grant_d;
      reject_q <= reject_d;
    end
  end

  assign grant_o  = grant_q;
  assign reject_o = reject_q;
  assign busy_o   = busy;
endmodule

// File: rtl/opx_arbiter_chk.sv
module opx_arbiter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic [3:0] req_op_i,
  input logic       grant_o,
  input logic       reject_o,
  input logic       busy_o,
  input logic [1:0] phase_o,
  input logic [7:0] status_o
);
  logic is_a, is_b, is_bad;
  assign is_b   = req_op_i <= 4'd2;
  assign is_a   = (req_op_i >= 4'd3) && (req_op_i <= 4'd11);
  assign is_bad = req_op_i >= 4'd12;

  assert_b_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && is_b |=> grant_o && !reject_o);
  assert_a_launch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && is_a && !busy_o |=> grant_o && busy_o && !status_o[7]);
  assert_a_refused_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && is_a && busy_o |=> reject_o && !grant_o);
  assert_phase_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != 2'd0) == busy_o);
  assert_phase_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(phase_o) == 2'd2 |-> phase_o != 2'd1);
  assert_cmp_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(status_o[6]));
  assert_bad_code_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && is_bad |=> reject_o && !grant_o);
  assert_no_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !grant_o && !reject_o);
endmodule

bind opx_arbiter opx_arbiter_chk u_chk (.*);

// File: tb/opx_arbiter_bench.sv
module opx_arbiter_bench;
  localparam int TR = 3, TX = 5, TP = 7, TE = 4, TB = 9;
  localparam logic [3:0] DEV = 4'b0101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, cmp_diff = 1'b0;
  logic [3:0] req_op = 4'd0;
  logic grant, reject, busy;
  logic [1:0] phase;
  logic [7:0] status;
  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic cmp_exp = 1'b0;

  always #2.5 clk = ~clk;

  opx_arbiter #(.T_READ(TR), .T_XFR(TX), .T_PGM(TP), .T_ERASE(TE),
    .T_BERASE(TB), .DEV_CODE(DEV)) u_opx_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_cmp_diff_i(cmp_diff), .grant_o(grant), .reject_o(reject),
    .busy_o(busy), .phase_o(phase), .status_o(status));

  function automatic int n1(int op);
    case (op)
      3: return TR; 4, 5, 11: return TX; 6, 8, 10: return TE;
      7: return TP; 9: return TB; default: return 0;
    endcase
  endfunction
  function automatic int n2(int op);
    return (op == 6 || op == 10 || op == 11) ? TP : 0;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(int op, bit d, bit intr_en, int iop, bit idiff);
    int n = 0;
    int a1 = n1(op);
    int len = n1(op) + n2(op);
    bit old6 = cmp_exp;
    @(negedge clk);
    req_valid = 1'b1; req_op = 4'(op); cmp_diff = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(grant == (op <= 11), "R2/R3 grant", int'(grant), int'(op <= 11));
    chk(reject == (op > 11), "R8 reject", int'(reject), int'(op > 11));
    while (busy && n < 100) begin
      n++;
      chk(phase == ((n <= a1) ? 2'd1 : 2'd2), "R5 phase", phase, (n <= a1) ? 1 : 2);
      chk(status[7] == 1'b0, "R6 busy bit", status[7], 0);
      chk(status[6] == old6, "R7 cmp hold", status[6], old6);
      if (n == 2 && intr_en) begin
        chk(grant == (iop <= 2), "R2/R4 intruder grant", grant, int'(iop <= 2));
        chk(reject == (iop > 2), "R4/R8 intruder reject", reject, int'(iop > 2));
      end
      if (n == 1 && intr_en) begin
        req_valid = 1'b1; req_op = 4'(iop); cmp_diff = idiff;
      end
      @(negedge clk);
      req_valid = 1'b0;
    end
    chk(n == len, "R3/R4/R5/R9 busy length", n, len);
    chk(phase == 2'd0 && status[7], "R6 ready after", {phase, status[7]}, 1);
    if (op == 5) cmp_exp = d;
    chk(status[6] == cmp_exp, "R7 cmp result", status[6], cmp_exp);
    chk(status[5:0] == {DEV, 2'b00}, "R9 low bits", status[5:0], {DEV, 2'b00});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!grant && !reject && !busy && phase == 0, "R1 reset outputs",
        {grant, reject, busy, phase}, 0);
    chk(status == {1'b1, 1'b0, DEV, 2'b00}, "R1 reset status", status,
        {1'b1, 1'b0, DEV, 2'b00});
    rst_n = 1'b1;
    @(negedge clk);
    // idle sweep over every code
    for (int op = 0; op < 16; op++) run(op, op[0], 1'b0, 0, 1'b0);
    // every array op against every intruder code
    for (int a = 3; a <= 11; a++)
      for (int x = 0; x < 16; x++)
        run(a, a[1], 1'b1, x, ~cmp_exp);
    // compare result posting
    run(5, 1'b1, 1'b0, 0, 1'b0);
    run(5, 1'b0, 1'b1, 5, 1'b1);
    run(5, 1'b1, 1'b1, 2, 1'b0);
    run(2, 1'b0, 1'b0, 0, 1'b0);
    chk(status[6] == 1'b1, "R7 buffer op keeps cmp", status[6], 1);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule